// File: doc/BRIEF.md
# Cascadable Offset-Sequence Counter

This block is a synchronous up-counter. It has a synchronous clear, a synchronous parallel load, two count-enable inputs and a carry output that can be chained to a following stage. The counter advances only while both enables are high. The carry output goes high when the counter holds its all-ones state, but only while the carry-path enable is also high. Tying one stage's carry output to the next stage's carry-path enable builds a wider counter that stays fully synchronous.

A small sequencing controller sits around the core. It uses the counter's own state to drive the core's load and clear, which gives shortened count cycles.

- **Start-offset mode:** the carry triggers a reload of a programmable start value. The count then runs from that value up to all ones and repeats.
- **End-offset mode:** a decoded terminal value triggers a synchronous clear. The count then runs from zero up to a programmable end value and repeats.
- **Plain mode:** the counter wraps through all of its states.

Top module: `offset_counter`

## Requirements
- R1: While `rst_n` is low, `cnt_o` is 0 and `carry_o` is 0.
- R2: With `clr_i` and `ld_i` low, and no sequencing action due, `cnt_o` increments by one, modulo 2^W, on a rising edge where `cnt_en_i` and `chain_en_i` are both 1. On any other edge it holds its value.
- R3: `carry_o` is 1 exactly when `cnt_o` is all ones and `chain_en_i` is 1, in the same cycle. `cnt_en_i` has no effect on `carry_o`.
- R4: `clr_i` high at a rising edge makes `cnt_o` 0 after that edge. This overrides load, count and every mode.
- R5: `ld_i` high with `clr_i` low at a rising edge makes `cnt_o` equal to `ld_val_i` after that edge. This happens regardless of the enables and the mode.
- R6: With `mode_i` = 2'b01 (start-offset), no clear and no load, an edge where `carry_o` and `cnt_en_i` are both 1 loads `start_val_i` instead of wrapping. With start value 0110 the sequence is 0110, 0111, ..., 1111, 0110.
- R7: With `mode_i` = 2'b10 (end-offset) and no external clear, an edge where `cnt_o` equals `end_val_i` and both enables are 1 clears the counter, even if `ld_i` is high. With end value 1101 the sequence is 0000, ..., 1101, 0000.
- R8: With `mode_i` = 2'b00 or 2'b11 (plain), the counter runs through all 2^W states and wraps from all ones to 0.
- R9: When a second stage's `chain_en_i` is fed from a first stage's `carry_o`, with both `cnt_en_i` at 1 and plain mode, the pair {second, first} counts as one 2W-bit binary counter. The second stage's carry rises at the combined all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear, highest priority |
| ld_i | input | 1 | Synchronous parallel load |
| ld_val_i | input | W | Value taken on load |
| cnt_en_i | input | 1 | Count enable, not part of the carry |
| chain_en_i | input | 1 | Count enable that also gates the carry; the cascade input |
| mode_i | input | 2 | 00/11 plain, 01 start-offset, 10 end-offset |
| start_val_i | input | W | Reload value in start-offset mode |
| end_val_i | input | W | Terminal value in end-offset mode |
| cnt_o | output | W | Current count |
| carry_o | output | 1 | All-ones indication, gated by `chain_en_i` |

## Verification
The hardest situation to reach from the ports is a sequencing action colliding with a stall or an external load. Examples are the all-ones state in start-offset mode while `cnt_en_i` is low, and the end value in end-offset mode while `ld_i` is high. Fixed-seed random stimulus holds both enables high most of the time and asserts clear and load rarely, so the counter often reaches its terminal states. Random mode, start and end values then make these collisions occur. Directed sequences pin down each full mode cycle, a stalled all-ones state and the two-stage 8-bit cascade through 255.

// File: rtl/offset_counter_pkg.sv
package offset_counter_pkg;
    typedef enum logic [1:0] {
        SEQ_PLAIN   = 2'b00,
        SEQ_START   = 2'b01,
        SEQ_END     = 2'b10,
        SEQ_PLAIN_B = 2'b11
    } seq_mode_e;

    typedef struct packed {
        logic clr;
        logic ld;
    } seq_cmd_t;
endpackage

// File: rtl/ctr_core.sv
module ctr_core #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         en_p,
    input  logic         en_t,
    output logic [W-1:0] cnt,
    output logic         carry
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (ld) begin
            st_d.cnt = ld_val;
        end else if (en_p && en_t) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign carry = (st_q.cnt == ALL_ONES) && en_t;

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld) |=> (cnt == $past(ld_val)));

    assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en_p && en_t) |=> (cnt == $past(cnt) + ONE));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && !(en_p && en_t)) |=> $stable(cnt));

    assert_carry_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_t |-> !carry);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import offset_counter_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] cnt,
    input  logic         carry,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] end_val,
    output seq_cmd_t     cmd
);
    seq_mode_e mode_sel;

    always_comb begin
        mode_sel = seq_mode_e'(mode);
        cmd      = '0;
        case (mode_sel)
            SEQ_START: cmd.ld  = carry && en_p;
            SEQ_END:   cmd.clr = (cnt == end_val) && en_p && en_t;
            default:   cmd     = '0;
        endcase
    end

    always_comb begin
        assert_cmd_exclusive_R6: assert (!(cmd.clr && cmd.ld));
    end
endmodule

// File: rtl/offset_counter.sv
module offset_counter
    import offset_counter_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         cnt_en_i,
    input  logic         chain_en_i,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] start_val_i,
    input  logic [W-1:0] end_val_i,
    output logic [W-1:0] cnt_o,
    output logic         carry_o
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    seq_cmd_t     seq_cmd;
    logic         core_clr_d;
    logic         core_ld_d;
    logic [W-1:0] core_val_d;
    logic [W-1:0] cnt_w;
    logic         carry_w;

    seq_ctrl #(.W(W)) u_seq (
        .mode    (mode_i),
        .cnt     (cnt_w),
        .carry   (carry_w),
        .en_p    (cnt_en_i),
        .en_t    (chain_en_i),
        .end_val (end_val_i),
        .cmd     (seq_cmd)
    );

    always_comb begin
        core_clr_d = clr_i || seq_cmd.clr;
        core_ld_d  = ld_i || seq_cmd.ld;
        core_val_d = ld_i ? ld_val_i : start_val_i;
    end

    ctr_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (core_clr_d),
        .ld     (core_ld_d),
        .ld_val (core_val_d),
        .en_p   (cnt_en_i),
        .en_t   (chain_en_i),
        .cnt    (cnt_w),
        .carry  (carry_w)
    );

    assign cnt_o   = cnt_w;
    assign carry_o = carry_w;

    assert_start_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && carry_o && cnt_en_i && !clr_i && !ld_i)
        |=> (cnt_o == $past(start_val_i)));

    assert_end_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && cnt_o == end_val_i && cnt_en_i && chain_en_i)
        |=> (cnt_o == '0));

    assert_plain_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 2'b00 || mode_i == 2'b11) && cnt_o == ALL_ONES
         && cnt_en_i && chain_en_i && !clr_i && !ld_i)
        |=> (cnt_o == '0));
endmodule

// File: tb/offset_counter_tb.sv
module offset_counter_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_i = 1'b0, ld_i = 1'b0, p_i = 1'b0, t_i = 1'b0;
    logic [W-1:0] ldv_i = '0, sv_i = '0, ev_i = '0;
    logic [1:0]   mode_i = 2'b00;
    logic [W-1:0] cnt_o;
    logic         carry_o;
    logic         hi_clr = 1'b0;
    logic [W-1:0] hi_cnt;
    logic         hi_carry;

    int n_chk = 0;
    int n_fail = 0;
    logic [W-1:0] ref_q = '0;
    string last_tag = "R1";

    always #4 clk = ~clk;

    offset_counter #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ld_i(ld_i), .ld_val_i(ldv_i),
        .cnt_en_i(p_i), .chain_en_i(t_i), .mode_i(mode_i),
        .start_val_i(sv_i), .end_val_i(ev_i), .cnt_o(cnt_o), .carry_o(carry_o)
    );

    offset_counter #(.W(W)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .clr_i(hi_clr), .ld_i(1'b0), .ld_val_i('0),
        .cnt_en_i(1'b1), .chain_en_i(carry_o), .mode_i(2'b00),
        .start_val_i('0), .end_val_i('0), .cnt_o(hi_cnt), .carry_o(hi_carry)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [W-1:0] q, input logic c, l,
                                           input logic [W-1:0] lv, input logic p, t,
                                           input logic [1:0] m, input logic [W-1:0] s, e);
        if (c) return '0;
        if (m == 2'b10 && q == e && p && t) return '0;
        if (l) return lv;
        if (m == 2'b01 && q == {W{1'b1}} && p && t) return s;
        if (p && t) return q + 1'b1;
        return q;
    endfunction

    function automatic string rule(input logic [W-1:0] q, input logic c, l, p, t,
                                   input logic [1:0] m, input logic [W-1:0] e);
        if (c) return "R4";
        if (m == 2'b10 && q == e && p && t) return "R7";
        if (l) return "R5";
        if (m == 2'b01 && q == {W{1'b1}} && p && t) return "R6";
        if (p && t && q == {W{1'b1}}) return "R8";
        return "R2";
    endfunction

    task automatic cyc(input logic c, l, input logic [W-1:0] lv, input logic p, t,
                       input logic [1:0] m, input logic [W-1:0] s, e);
        @(negedge clk);
        clr_i = c; ld_i = l; ldv_i = lv; p_i = p; t_i = t; mode_i = m; sv_i = s; ev_i = e;
        #1;
        check(cnt_o == ref_q, last_tag, cnt_o, ref_q);
        check(carry_o == ((ref_q == {W{1'b1}}) && t), "R3", carry_o, (ref_q == {W{1'b1}}) && t);
        last_tag = rule(ref_q, c, l, p, t, m, e);
        ref_q = model(ref_q, c, l, lv, p, t, m, s, e);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        logic [7:0] exp8;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cnt_o == '0, "R1", cnt_o, 0);
        check(carry_o == 1'b0, "R1", carry_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        ref_q = '0;

        // R8 plain full cycle and wrap, R3 carry at all ones
        for (int i = 0; i < 18; i++) cyc(0, 0, 0, 1, 1, 2'b00, 0, 0);
        for (int i = 0; i < 18; i++) cyc(0, 0, 0, 1, 1, 2'b11, 0, 0);

        // R3 stalled stage at all ones: T low -> no carry; P low -> carry but hold
        cyc(0, 1, 4'hF, 1, 1, 2'b00, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 2'b01, 4'h6, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 2'b01, 4'h6, 0);

        // R6 start-offset with start 0110
        for (int i = 0; i < 24; i++) cyc(0, 0, 0, 1, 1, 2'b01, 4'h6, 0);

        // R7 end-offset with end 1101, starting from clear
        cyc(1, 0, 0, 1, 1, 2'b10, 0, 4'hD);
        for (int i = 0; i < 30; i++) cyc(0, 0, 0, 1, 1, 2'b10, 0, 4'hD);
        // R7 terminal clear beats an external load
        cyc(0, 1, 4'hD, 1, 1, 2'b00, 0, 4'hD);
        cyc(0, 1, 4'h9, 1, 1, 2'b10, 0, 4'hD);
        cyc(0, 0, 0, 0, 0, 2'b10, 0, 4'hD);

        // R4 clear over load, R5 load over count with enables off
        cyc(0, 1, 4'hA, 1, 1, 2'b00, 0, 0);
        cyc(1, 1, 4'h5, 1, 1, 2'b00, 0, 0);
        cyc(0, 1, 4'h7, 0, 0, 2'b00, 0, 0);
        cyc(0, 1, 4'h3, 1, 1, 2'b01, 4'h9, 0);
        cyc(0, 0, 0, 0, 0, 2'b00, 0, 0);

        // Random mix
        for (int i = 0; i < 1500; i++) begin
            cyc(($urandom % 40) == 0, ($urandom % 20) == 0, W'($urandom),
                ($urandom % 10) != 0, ($urandom % 8) != 0, 2'($urandom),
                W'($urandom), W'($urandom));
        end

        // R9 two-stage cascade, plain mode
        @(negedge clk);
        clr_i = 1'b1; hi_clr = 1'b1; ld_i = 1'b0; p_i = 1'b1; t_i = 1'b1; mode_i = 2'b00;
        @(negedge clk);
        clr_i = 1'b0; hi_clr = 1'b0;
        exp8 = 8'd0;
        for (int i = 0; i < 300; i++) begin
            #1;
            check({hi_cnt, cnt_o} == exp8, "R9", {hi_cnt, cnt_o}, exp8);
            check(hi_carry == (exp8 == 8'hFF), "R9", hi_carry, exp8 == 8'hFF);
            exp8 = exp8 + 8'd1;
            @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule